// File: doc/BRIEF.md
# OTP Fuse Controller Register Sequencer

This block is the register front end for a one-time-programmable fuse array. Software reaches it over a plain register bus with address, write strobe, read strobe, write data and combinational read data. A control register holds the target word, the status flags, a reload request and a write key. Set and clear aliases allow single bits to be changed without a read-modify-write. Other registers hold the program strobe length and the data word to burn. A bank of shadow registers mirrors the fuse contents for fast reads.

A program access needs three steps. Software places the word address and the unlock key in the control register, then writes the data register. The controller then captures its own copy of the address and data, raises BUSY and runs a fuse program engine for a timed strobe. Fuse bits can only go from zero to one. Words in a program-locked range refuse the access. Words in a read-locked range return a poison value. Either case raises a sticky ERROR flag, which must be cleared before the controller accepts anything further. A reload request copies every fuse word into the shadow bank, one word per cycle, and the request bit clears itself when the copy is done.

A small behavioural fuse array stands in for the silicon. Its lock ranges are fixed by parameters.

Top module: `otpc_top`

## Requirements
- R1: After reset the control register reads 0, the timing register reads the DEF_STROBE parameter (default 6), the data register reads 0 and every shadow word reads 0.
- R2: Control register layout: word address in [7:0], BUSY in bit 8, ERROR in bit 9, reload request in bit 10, unlock key in [31:16]. The register is at offset 0x000, a set alias at 0x004 ORs the written bits in, and a clear alias at 0x008 clears them. The timing register is at 0x010 and the data register at 0x020. BUSY and ERROR cannot be set by software.
- R3: A data-register write starts a program only when control [31:16] holds 0x3E77. Every accepted data write stores the data and clears the key to 0. Without the exact key, no fuse is programmed.
- R4: An accepted program raises BUSY on the write edge. BUSY stays high for timing[11:0]+2 cycles in total. The fuse word becomes its old value OR the data.
- R5: While BUSY is high, writes to the control, set, timing and data registers are ignored. The operation completes on the address and data captured when it was accepted.
- R6: A program request to a word in the program-locked range (96..103 by default) or beyond the last word sets ERROR, does not raise BUSY and leaves the fuse unchanged.
- R7: ERROR is sticky. While it is set, control, set, timing, data and shadow writes are ignored and shadow reads return 0xBADABADA. Writing bit 9 to the clear alias clears it.
- R8: A read of a shadow word in the read-locked range (120..127 by default) returns 0xBADABADA and sets ERROR.
- R9: Setting bit 10 copies all fuse words into the shadow bank, and bit 10 then clears by itself.
- R10: Shadow words may be written through the bus when the controller is idle. A shadow write to a program-locked word, or any shadow write while bit 10 is set, sets ERROR and changes nothing.
- R11: Shadow word i is at 0x400 + 16*i. An address that is not 16-aligned or whose index is at or beyond NWORDS reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_re | input | 1 | Read strobe; needed for the read-lock error side effect |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The assertions assume that each bus strobe lasts one cycle and that read and write strobes never target the same register in the same cycle. They also assume the bus address is driven whenever a strobe is high. The bench drives every access through one task per access type, and each task holds a strobe for exactly one clock. It waits for BUSY and the reload bit to clear by polling the control register. Random programs pick only unlocked words, or deliberately locked ones whose expected ERROR outcome is checked.

// File: rtl/otpc_pkg.sv
package otpc_pkg;
  localparam int unsigned REG_CTRL    = 32'h000;
  localparam int unsigned REG_SET     = 32'h004;
  localparam int unsigned REG_CLR     = 32'h008;
  localparam int unsigned REG_TIMING  = 32'h010;
  localparam int unsigned REG_DATA    = 32'h020;
  localparam int unsigned SHADOW_BASE = 32'h400;

  localparam int BIT_BUSY   = 8;
  localparam int BIT_ERR    = 9;
  localparam int BIT_RELOAD = 10;

  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
  localparam logic [31:0] POISON     = 32'hBADA_BADA;
  // Software-writable control bits: everything except BUSY and ERROR.
  localparam logic [31:0] CTRL_WMASK = 32'hFFFF_FCFF;

  function automatic logic in_range(input logic [31:0] v, input int unsigned lo,
                                    input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/otpc_prog_engine.sv
module otpc_prog_engine #(
  parameter int unsigned IW = 7,
  parameter int unsigned TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] addr_in,
  input  logic [31:0]   data_in,
  input  logic [TW-1:0] strobe,
  output logic          done,
  output logic [IW-1:0] addr_o,
  output logic [31:0]   data_o
);
  logic          active_q, active_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] addr_q, addr_d;
  logic [31:0]   data_q, data_d;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    addr_d   = addr_q;
    data_d   = data_q;
    done     = active_q && (cnt_q == '0);
    if (start && !active_q) begin
      active_d = 1'b1;
      cnt_d    = strobe;
      addr_d   = addr_in;
      data_d   = data_in;
    end else if (active_q) begin
      if (cnt_q == '0) active_d = 1'b0;
      else             cnt_d    = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      addr_q   <= addr_d;
      data_q   <= data_d;
    end
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/otpc_fuse_array.sv
module otpc_fuse_array #(
  parameter int unsigned NWORDS = 128,
  parameter int unsigned IW     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_data
);
  logic [31:0] word_bus [NWORDS];

  for (genvar g = 0; g < int'(NWORDS); g++) begin : g_word
    logic [31:0] fz_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              fz_q <= '0;
      else if (wr_en && (wr_idx == IW'(g)))    fz_q <= fz_q | wr_data;
    end
    assign word_bus[g] = fz_q;
  end

  assign rd_data = word_bus[rd_idx];
endmodule

// File: rtl/otpc_shadow_bank.sv
module otpc_shadow_bank #(
  parameter int unsigned NWORDS = 128,
  parameter int unsigned IW     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload_req,
  output logic          reload_done,
  output logic [IW-1:0] fuse_rd_idx,
  input  logic [31:0]   fuse_rd_data,
  input  logic          bus_we,
  input  logic [IW-1:0] bus_idx,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   rd_data
);
  localparam logic [IW-1:0] LAST = IW'(NWORDS - 1);

  logic          active_q, active_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [31:0]   sh_bus [NWORDS];

  always_comb begin
    active_d    = active_q;
    idx_d       = idx_q;
    reload_done = active_q && (idx_q == LAST);
    if (!active_q && reload_req) begin
      active_d = 1'b1;
      idx_d    = '0;
    end else if (active_q) begin
      if (idx_q == LAST) active_d = 1'b0;
      else               idx_d    = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
    end
  end

  for (genvar g = 0; g < int'(NWORDS); g++) begin : g_sh
    logic [31:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  sh_q <= '0;
      else if (active_q && (idx_q == IW'(g)))      sh_q <= fuse_rd_data;
      else if (bus_we && (bus_idx == IW'(g)))      sh_q <= bus_wdata;
    end
    assign sh_bus[g] = sh_q;
  end

  assign fuse_rd_idx = idx_q;
  assign rd_data     = sh_bus[bus_idx];
endmodule

// File: rtl/otpc_top.sv
module otpc_top
  import otpc_pkg::*;
#(
  parameter int unsigned NWORDS     = 128,
  parameter int unsigned DEF_STROBE = 6,
  parameter int unsigned PLOCK_LO   = 96,
  parameter int unsigned PLOCK_HI   = 103,
  parameter int unsigned RLOCK_LO   = 120,
  parameter int unsigned RLOCK_HI   = 127,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int unsigned IW = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int unsigned TW = 12;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_n_i, rst_meta} <= 2'b00;
    else        {rst_n_i, rst_meta} <= {rst_meta, 1'b1};
  end

  logic [31:0]   ctrl_q, ctrl_d, timing_q, timing_d, data_q, data_d;
  logic          busy_q, busy_d, err_q, err_d, start_q, start_d;
  logic          eng_done, reload_done, sh_we;
  logic [IW-1:0] eng_idx, fuse_rd_idx;
  logic [31:0]   eng_data, fuse_rd_data, sh_rd_data;

  // address decode
  logic [31:0]   a32, sh_off, sh_word, cur_word;
  logic [IW-1:0] sh_idx, cur_idx;
  logic hit_ctrl, hit_set, hit_clr, hit_tim, hit_data, hit_sh;
  logic sh_plk, sh_rlk, cur_lock, blocked;

  always_comb begin
    a32      = 32'(bus_addr);
    hit_ctrl = (a32 == REG_CTRL);
    hit_set  = (a32 == REG_SET);
    hit_clr  = (a32 == REG_CLR);
    hit_tim  = (a32 == REG_TIMING);
    hit_data = (a32 == REG_DATA);
    sh_off   = a32 - SHADOW_BASE;
    sh_word  = sh_off >> 4;
    hit_sh   = (a32 >= SHADOW_BASE) && (a32[3:0] == 4'h0) && (sh_word < NWORDS);
    sh_idx   = sh_word[IW-1:0];
    sh_plk   = in_range(sh_word, PLOCK_LO, PLOCK_HI);
    sh_rlk   = hit_sh && in_range(sh_word, RLOCK_LO, RLOCK_HI);
    cur_word = {24'h0, ctrl_q[7:0]};
    cur_idx  = cur_word[IW-1:0];
    cur_lock = (cur_word >= NWORDS) || in_range(cur_word, PLOCK_LO, PLOCK_HI);
    blocked  = busy_q || err_q || ctrl_q[BIT_RELOAD];
  end

  // next state
  always_comb begin
    ctrl_d   = ctrl_q;
    timing_d = timing_q;
    data_d   = data_q;
    busy_d   = busy_q;
    err_d    = err_q;
    start_d  = 1'b0;
    sh_we    = 1'b0;
    if (bus_we) begin
      if (hit_ctrl && !blocked) ctrl_d = bus_wdata & CTRL_WMASK;
      if (hit_set && !blocked)  ctrl_d = ctrl_q | (bus_wdata & CTRL_WMASK);
      if (hit_clr) begin
        if (bus_wdata[BIT_ERR]) err_d = 1'b0;
        if (!blocked) ctrl_d = ctrl_q & ~(bus_wdata & CTRL_WMASK);
      end
      if (hit_tim && !blocked) timing_d = bus_wdata;
      if (hit_data && !blocked) begin
        data_d        = bus_wdata;
        ctrl_d[31:16] = 16'h0;
        if (ctrl_q[31:16] == UNLOCK_KEY) begin
          if (cur_lock) err_d = 1'b1;
          else begin
            busy_d  = 1'b1;
            start_d = 1'b1;
          end
        end
      end
      if (hit_sh) begin
        if (ctrl_q[BIT_RELOAD] || sh_plk) err_d = 1'b1;
        else if (!busy_q && !err_q)       sh_we = 1'b1;
      end
    end
    if (bus_re && sh_rlk) err_d = 1'b1;
    if (eng_done)    busy_d = 1'b0;
    if (reload_done) ctrl_d[BIT_RELOAD] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ctrl_q   <= '0;
      timing_q <= 32'(DEF_STROBE);
      data_q   <= '0;
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      timing_q <= timing_d;
      data_q   <= data_d;
      busy_q   <= busy_d;
      err_q    <= err_d;
      start_q  <= start_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl || hit_set || hit_clr)
      bus_rdata = ctrl_q | (32'(busy_q) << BIT_BUSY) | (32'(err_q) << BIT_ERR);
    else if (hit_tim)  bus_rdata = timing_q;
    else if (hit_data) bus_rdata = data_q;
    else if (hit_sh)   bus_rdata = (sh_rlk || err_q) ? POISON : sh_rd_data;
  end

  otpc_prog_engine #(.IW(IW), .TW(TW)) u_engine (
    .clk(clk), .rst_n(rst_n_i), .start(start_q), .addr_in(cur_idx),
    .data_in(data_q), .strobe(timing_q[TW-1:0]), .done(eng_done),
    .addr_o(eng_idx), .data_o(eng_data)
  );

  otpc_fuse_array #(.NWORDS(NWORDS), .IW(IW)) u_fuse (
    .clk(clk), .rst_n(rst_n_i), .wr_en(eng_done), .wr_idx(eng_idx),
    .wr_data(eng_data), .rd_idx(fuse_rd_idx), .rd_data(fuse_rd_data)
  );

  otpc_shadow_bank #(.NWORDS(NWORDS), .IW(IW)) u_shadow (
    .clk(clk), .rst_n(rst_n_i), .reload_req(ctrl_q[BIT_RELOAD]),
    .reload_done(reload_done), .fuse_rd_idx(fuse_rd_idx),
    .fuse_rd_data(fuse_rd_data), .bus_we(sh_we), .bus_idx(sh_idx),
    .bus_wdata(bus_wdata), .rd_data(sh_rd_data)
  );
endmodule

// File: rtl/otpc_checker.sv
module otpc_checker
  import otpc_pkg::*;
#(
  parameter int unsigned NWORDS   = 128,
  parameter int unsigned PLOCK_LO = 96,
  parameter int unsigned PLOCK_HI = 103,
  parameter int unsigned RLOCK_LO = 120,
  parameter int unsigned RLOCK_HI = 127,
  parameter int unsigned ADDR_W   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              busy,
  input logic              err,
  input logic [31:0]       ctrl,
  input logic [31:0]       data
);
  logic [31:0] a32;
  logic        idle, keyed, data_wr, clr_err, rlk_read;

  always_comb begin
    a32      = 32'(bus_addr);
    idle     = !busy && !err && ((ctrl & (32'h1 << BIT_RELOAD)) == '0);
    keyed    = (ctrl >> 16) == 32'(UNLOCK_KEY);
    data_wr  = bus_we && (a32 == REG_DATA);
    clr_err  = bus_we && (a32 == REG_CLR) && ((bus_wdata & (32'h1 << BIT_ERR)) != '0);
    rlk_read = bus_re && (a32[3:0] == 4'h0) && (a32 < SHADOW_BASE + 16 * NWORDS)
               && (a32 >= SHADOW_BASE + 16 * RLOCK_LO)
               && (a32 <= SHADOW_BASE + 16 * RLOCK_HI);
  end

  // R3: an accepted data write always clears the key
  a_r3_key_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && idle |=> (ctrl & 32'hFFFF_0000) == '0);

  // R4: BUSY only rises after a keyed data write
  a_r4_busy_from_keyed_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(data_wr && keyed));

  // R5: data register frozen while busy
  a_r5_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(data));

  // R6: keyed program to a locked word gives ERROR and no BUSY
  a_r6_locked_refused: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && idle && keyed && in_range({24'h0, ctrl[7:0]}, PLOCK_LO, PLOCK_HI)
    |=> err && !busy);

  // R7: ERROR holds until cleared through the clear alias
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err && !clr_err |=> err);

  // R8: read-locked shadow reads return poison
  a_r8_poison: assert property (@(posedge clk) disable iff (!rst_n)
    rlk_read |-> bus_rdata == POISON);
endmodule

bind otpc_top otpc_checker #(
  .NWORDS(NWORDS), .PLOCK_LO(PLOCK_LO), .PLOCK_HI(PLOCK_HI),
  .RLOCK_LO(RLOCK_LO), .RLOCK_HI(RLOCK_HI), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .busy(busy_q), .err(err_q), .ctrl(ctrl_q), .data(data_q)
);

// File: tb/otpc_top_bench.sv
`timescale 1ns/1ps
module otpc_top_bench;
  localparam int NW  = 128;
  localparam int STB = 6;
  localparam logic [31:0] KEYW   = 32'h3E77_0000;
  localparam logic [31:0] POISON = 32'hBADA_BADA;
  localparam logic [11:0] A_CTRL = 12'h000, A_SET = 12'h004, A_CLR = 12'h008,
                          A_TIM = 12'h010, A_DATA = 12'h020;

  logic        clk, rst_n, bus_we, bus_re;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int          n_tests, n_fail;
  logic [31:0] model [NW];

  otpc_top u_otpc_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic plk(int i); return i >= 96 && i <= 103; endfunction
  function automatic logic rlk(int i); return i >= 120 && i <= 127; endfunction
  function automatic logic [11:0] sh_a(int i); return 12'(32'h400 + 16 * i); endfunction
  function automatic logic [31:0] exp_shadow(int i);
    return rlk(i) ? POISON : model[i];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all access tasks are entered at a falling edge and return at one
  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 1000; k++) begin
      rd(A_CTRL, v);
      if (!v[8] && !v[10]) break;
    end
  endtask

  task automatic prog(int idx, logic [31:0] d);
    wr(A_CTRL, KEYW | 32'(idx));
    wr(A_DATA, d);
    wait_idle();
    if (!plk(idx)) model[idx] = model[idx] | d;
  endtask

  task automatic reload();
    wr(A_SET, 32'h400);
    wait_idle();
  endtask

  task automatic clr_err();
    wr(A_CLR, 32'h200);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int unsigned sd;
    n_tests = 0; n_fail = 0;
    for (int i = 0; i < NW; i++) model[i] = '0;
    bus_we = 0; bus_re = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v);   chk("R1 ctrl", v, 32'h0);
    rd(A_TIM, v);    chk("R1 timing", v, 32'(STB));
    rd(A_DATA, v);   chk("R1 data", v, 32'h0);
    rd(sh_a(5), v);  chk("R1 shadow", v, 32'h0);

    // R2 control layout and aliases
    wr(A_CTRL, 32'h0000_0312);           // bits 8,9 not writable
    rd(A_CTRL, v);   chk("R2 ctrl write", v, 32'h0000_0012);
    wr(A_SET, KEYW);
    rd(A_SET, v);    chk("R2 set alias", v, 32'h3E77_0012);
    wr(A_CLR, 32'hFFFF_0000);
    rd(A_CLR, v);    chk("R2 clear alias", v, 32'h0000_0012);

    // R3 no key / wrong key: data stored, nothing programmed
    wr(A_CTRL, 32'h0000_0004);
    wr(A_DATA, 32'h0000_00FF);
    rd(A_CTRL, v);   chk("R3 no busy without key", v, 32'h0000_0004);
    rd(A_DATA, v);   chk("R3 data stored", v, 32'h0000_00FF);
    wr(A_CTRL, 32'h3E76_0004);
    wr(A_DATA, 32'h0000_00F0);
    rd(A_CTRL, v);   chk("R3 wrong key cleared", v, 32'h0000_0004);
    reload();
    rd(sh_a(4), v);  chk("R3 fuse untouched", v, 32'h0);

    // R4 busy window and OR programming
    wr(A_CTRL, KEYW | 32'd7);
    wr(A_DATA, 32'h0000_00A5);
    for (int k = 0; k <= STB + 2; k++) begin
      rd(A_CTRL, v);
      if (k == 0 || k == STB + 1)
        chk("R4 busy held", {31'h0, v[8]}, 32'h1);
      if (k == STB + 2)
        chk("R4 busy cleared", {31'h0, v[8]}, 32'h0);
    end
    model[7] = 32'h0000_00A5;
    rd(A_CTRL, v);   chk("R3 key cleared after program", v, 32'h0000_0007);
    prog(7, 32'h0000_5A0F);
    reload();
    rd(sh_a(7), v);  chk("R4 fuse OR", v, exp_shadow(7));

    // R5 writes during busy ignored
    wr(A_CTRL, KEYW | 32'd9);
    wr(A_DATA, 32'h0000_00F0);
    wr(A_CTRL, KEYW | 32'd10);
    wr(A_DATA, 32'hDEAD_BEEF);
    wr(A_TIM, 32'h0000_0055);
    wait_idle();
    model[9] = model[9] | 32'h0000_00F0;
    rd(A_CTRL, v);   chk("R5 ctrl unchanged", v, 32'h0000_0009);
    rd(A_DATA, v);   chk("R5 data frozen", v, 32'h0000_00F0);
    rd(A_TIM, v);    chk("R5 timing unchanged", v, 32'(STB));
    reload();
    rd(sh_a(9), v);  chk("R5 captured addr", v, exp_shadow(9));
    rd(sh_a(10), v); chk("R5 other word clean", v, exp_shadow(10));

    // R6 locked program, R7 sticky error
    wr(A_CTRL, KEYW | 32'd98);
    wr(A_DATA, 32'hFFFF_FFFF);
    rd(A_CTRL, v);   chk("R6 error no busy", v, 32'h0000_0262);
    wr(A_CTRL, 32'h0000_0055);
    rd(A_CTRL, v);   chk("R7 ctrl write blocked", v, 32'h0000_0262);
    rd(sh_a(7), v);  chk("R7 shadow poison while error", v, POISON);
    clr_err();
    rd(A_CTRL, v);   chk("R7 error cleared", v, 32'h0000_0062);
    rd(sh_a(7), v);  chk("R7 shadow after clear", v, exp_shadow(7));
    reload();
    rd(sh_a(98), v); chk("R6 fuse unchanged", v, 32'h0);

    // R8 read-locked word
    rd(sh_a(121), v); chk("R8 poison", v, POISON);
    rd(A_CTRL, v);    chk("R8 error set", {31'h0, v[9]}, 32'h1);
    clr_err();

    // R10 shadow writes
    wr(sh_a(30), 32'h0000_1234);
    rd(sh_a(30), v);  chk("R10 shadow write", v, 32'h0000_1234);
    wr(sh_a(100), 32'h0000_0001);
    rd(A_CTRL, v);    chk("R10 locked shadow error", {31'h0, v[9]}, 32'h1);
    clr_err();
    rd(sh_a(100), v); chk("R10 locked shadow unchanged", v, 32'h0);
    wr(A_SET, 32'h400);
    wr(sh_a(31), 32'h0000_0077);
    wait_idle();
    rd(A_CTRL, v);    chk("R10 write during reload error", {31'h0, v[9]}, 32'h1);
    chk("R9 reload bit self-clears", {31'h0, v[10]}, 32'h0);
    clr_err();
    rd(sh_a(31), v);  chk("R10 reload wins", v, exp_shadow(31));
    rd(sh_a(30), v);  chk("R9 reload overwrote shadow", v, exp_shadow(30));

    // R11 address map edges
    rd(12'(32'h400 + 16 * NW), v); chk("R11 beyond last", v, 32'h0);
    rd(12'h404, v);                chk("R11 misaligned", v, 32'h0);

    // random programs
    sd = $urandom(32'd2024);
    for (int it = 0; it < 24; it++) begin
      int idx;
      logic [31:0] d;
      d = $urandom() & $urandom();
      if ((it % 6) == 5) begin
        idx = 96 + int'($urandom_range(0, 7));
        wr(A_CTRL, KEYW | 32'(idx));
        wr(A_DATA, d);
        rd(A_CTRL, v); chk("R6 random locked", {31'h0, v[9]}, 32'h1);
        clr_err();
      end else begin
        idx = int'($urandom_range(0, 95));
        prog(idx, d);
      end
    end
    reload();
    for (int it = 0; it < 16; it++) begin
      int idx;
      idx = int'($urandom_range(0, 119));
      rd(sh_a(idx), v); chk("R9 random readback", v, exp_shadow(idx));
    end

    finish_run();
  end
endmodule